// File: doc/BRIEF.md
# Misrouted Cell Header Capture Monitor

This block sits beside the routing stage of a cell-switching interconnect and watches every cell header as it arrives. Each header comes on a one-cycle valid strobe, together with the index of the lookup-table space that routed it. The block applies a few routing sanity checks to the header, using static per-table configuration: an inclusive VCI window, a VPI-check enable and a mask of VPI bits the table does not use. Any cell that fails a check counts as misrouted.

For the first misrouted cell after a clear, the block keeps the full 32-bit header and sets a latched status bit. On every misrouted cell it also records which table space the cell came from. Software reaches all of this through a small 16-bit register window. That window holds a per-table monitor mask and a control/status word, which carries a self-clearing clear command. Two further read-only words return the two halves of the stored header.

Top module: `misroute_mon`

## Requirements
- R1: After reset the registers read as follows: the mask word (offset 0142h) reads FFFFh; the control/status word (0144h) reads 0000h; the header words (0146h and 0148h) read 0000h.
- R2: A cell whose table index has its bit cleared in the mask word (bit n for table n) is never treated as misrouted. It causes no capture and leaves the last-table field unchanged.
- R3: A cell is misrouted when header bits 3 and 2 are both 0. These are the two routing-class bits.
- R4: A cell is misrouted when its VCI is below or above the table's inclusive VCI bounds. The VCI is header bits 19:4. A VCI equal to either bound is accepted.
- R5: When the VPI-check enable of the cell's table is 1, a cell is misrouted if any VPI bit selected by that table's unused-bit mask is 1. The VPI is header bits 31:20. When the enable is 0, those bits are ignored.
- R6: The first misrouted cell while the latched bit is 0 stores its header and sets the latched bit, which is control/status bit 1. Header bits 31:16 then read at 0146h and bits 15:0 read at 0148h.
- R7: While the latched bit is 1, further misrouted cells do not change the stored header.
- R8: Every misrouted cell writes its table index into control/status bits 7:4.
- R9: Writing a 1 to control/status bit 0 clears the latched bit and sets the stored header to 0 at that clock edge. Bit 0 always reads 0.
- R10: If a clear and a misrouted cell occur in the same cycle, the clear wins and the header is not captured. The last-table field still updates.
- R11: Read data appears on the clock edge after the address is presented. Reserved bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_vld | input | 1 | One-cycle strobe qualifying header and table index |
| cell_hdr | input | 32 | Incoming cell header |
| cell_tbl | input | 4 | Lookup-table space that routed the cell |
| cfg_vci_min | input | 256 | Per-table VCI lower bound, 16 bits per table |
| cfg_vci_max | input | 256 | Per-table VCI upper bound, 16 bits per table |
| cfg_vpi_chk | input | 16 | Per-table VPI-check enable |
| cfg_vpi_unused | input | 192 | Per-table mask of unused VPI bits, 12 bits per table |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |

## Verification
The assertions assume the configuration inputs stay constant while cells flow. They also assume cell_tbl is meaningful only when cell_vld is high, and that a clear command is a single write strobe. The stimulus sets the configuration once, before reset is released. It then drives each cell and each write for exactly one cycle, starting at a falling edge. A clear and a misrouted cell are put in the same cycle only in the one case that exercises the clear's priority.

// File: rtl/misroute_pkg.sv
package misroute_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] A_MASK = 16'h0142;
  localparam logic [ADDR_W-1:0] A_CTRL = 16'h0144;
  localparam logic [ADDR_W-1:0] A_HDRH = 16'h0146;
  localparam logic [ADDR_W-1:0] A_HDRL = 16'h0148;

  // control/status bit layout
  localparam int CTRL_CLR_BIT  = 0;
  localparam int CTRL_LAT_BIT  = 1;
  localparam int CTRL_LAST_LSB = 4;

  // header field layout
  localparam int HDR_W    = 32;
  localparam int VPI_LSB  = 20;
  localparam int VPI_W    = 12;
  localparam int VCI_LSB  = 4;
  localparam int VCI_W    = 16;
  localparam int CLS_LSB  = 2;
  localparam int CLS_W    = 2;

  typedef struct packed {
    logic [VPI_W-1:0] vpi;
    logic [VCI_W-1:0] vci;
    logic [CLS_W-1:0] cls;
  } hdr_fields_t;

  function automatic hdr_fields_t split_hdr(input logic [HDR_W-1:CLS_LSB] h);
    hdr_fields_t f;
    f.vpi = h[VPI_LSB +: VPI_W];
    f.vci = h[VCI_LSB +: VCI_W];
    f.cls = h[CLS_LSB +: CLS_W];
    return f;
  endfunction
endpackage

// File: rtl/misroute_check.sv
module misroute_check
  import misroute_pkg::*;
#(
  parameter int NTBL  = 16,
  parameter int TBL_W = $clog2(NTBL)
) (
  input  logic                    cell_vld,
  input  logic [HDR_W-1:CLS_LSB]  cell_hdr_top,
  input  logic [TBL_W-1:0]        cell_tbl,
  input  logic [NTBL*VCI_W-1:0]   cfg_vci_min,
  input  logic [NTBL*VCI_W-1:0]   cfg_vci_max,
  input  logic [NTBL-1:0]         cfg_vpi_chk,
  input  logic [NTBL*VPI_W-1:0]   cfg_vpi_unused,
  input  logic [NTBL-1:0]         mon_mask,
  output logic                    hit
);
  hdr_fields_t f;
  logic [NTBL-1:0] bad_vec;

  always_comb f = split_hdr(cell_hdr_top);

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic [VCI_W-1:0] lo_b, hi_b;
    logic [VPI_W-1:0] umask;
    logic             cls_bad, vci_bad, vpi_bad;
    assign lo_b    = cfg_vci_min[t*VCI_W +: VCI_W];
    assign hi_b    = cfg_vci_max[t*VCI_W +: VCI_W];
    assign umask   = cfg_vpi_unused[t*VPI_W +: VPI_W];
    assign cls_bad = (f.cls == '0);
    assign vci_bad = (f.vci < lo_b) || (f.vci > hi_b);
    assign vpi_bad = cfg_vpi_chk[t] && ((f.vpi & umask) != '0);
    assign bad_vec[t] = cls_bad | vci_bad | vpi_bad;
  end

  always_comb begin
    hit = 1'b0;
    if (cell_vld && mon_mask[cell_tbl] && bad_vec[cell_tbl])
      hit = 1'b1;
  end
endmodule

// File: rtl/misroute_capture.sv
module misroute_capture
  import misroute_pkg::*;
#(
  parameter int TBL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              clr,
  input  logic [HDR_W-1:0]  cell_hdr,
  input  logic [TBL_W-1:0]  cell_tbl,
  output logic [HDR_W-1:0]  hdr_q,
  output logic              latched,
  output logic [TBL_W-1:0]  last_tbl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q   <= '0;
      latched <= 1'b0;
    end else if (clr) begin
      hdr_q   <= '0;
      latched <= 1'b0;
    end else if (hit && !latched) begin
      hdr_q   <= cell_hdr;
      latched <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_tbl <= '0;
    else if (hit)
      last_tbl <= cell_tbl;
  end
endmodule

// File: rtl/misroute_regs.sv
module misroute_regs
  import misroute_pkg::*;
#(
  parameter int NTBL  = 16,
  parameter int TBL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              latched,
  input  logic [TBL_W-1:0]  last_tbl,
  input  logic [HDR_W-1:0]  hdr_q,
  output logic [NTBL-1:0]   mon_mask,
  output logic              clr,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [REG_W-1:0] rd_mux;

  assign clr = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      mon_mask <= '1;
    else if (reg_wr && reg_addr == A_MASK)
      mon_mask <= reg_wdata[NTBL-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_MASK: rd_mux[NTBL-1:0] = mon_mask;
      A_CTRL: begin
        rd_mux[CTRL_LAT_BIT]                  = latched;
        rd_mux[CTRL_LAST_LSB +: TBL_W]        = last_tbl;
      end
      A_HDRH: rd_mux = hdr_q[HDR_W-1:REG_W];
      A_HDRL: rd_mux = hdr_q[REG_W-1:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/misroute_mon.sv
module misroute_mon
  import misroute_pkg::*;
#(
  parameter int NTBL  = 16,
  parameter int TBL_W = $clog2(NTBL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cell_vld,
  input  logic [HDR_W-1:0]      cell_hdr,
  input  logic [TBL_W-1:0]      cell_tbl,
  input  logic [NTBL*VCI_W-1:0] cfg_vci_min,
  input  logic [NTBL*VCI_W-1:0] cfg_vci_max,
  input  logic [NTBL-1:0]       cfg_vpi_chk,
  input  logic [NTBL*VPI_W-1:0] cfg_vpi_unused,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata
);
  logic             hit, clr, latched;
  logic [NTBL-1:0]  mon_mask;
  logic [HDR_W-1:0] hdr_q;
  logic [TBL_W-1:0] last_tbl;

  misroute_check #(.NTBL(NTBL), .TBL_W(TBL_W)) u_check (
    .cell_vld      (cell_vld),
    .cell_hdr_top  (cell_hdr[HDR_W-1:CLS_LSB]),
    .cell_tbl      (cell_tbl),
    .cfg_vci_min   (cfg_vci_min),
    .cfg_vci_max   (cfg_vci_max),
    .cfg_vpi_chk   (cfg_vpi_chk),
    .cfg_vpi_unused(cfg_vpi_unused),
    .mon_mask      (mon_mask),
    .hit           (hit)
  );

  misroute_capture #(.TBL_W(TBL_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .clr     (clr),
    .cell_hdr(cell_hdr),
    .cell_tbl(cell_tbl),
    .hdr_q   (hdr_q),
    .latched (latched),
    .last_tbl(last_tbl)
  );

  misroute_regs #(.NTBL(NTBL), .TBL_W(TBL_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .latched  (latched),
    .last_tbl (last_tbl),
    .hdr_q    (hdr_q),
    .mon_mask (mon_mask),
    .clr      (clr),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/misroute_mon_sva.sv
module misroute_mon_sva #(
  parameter int NTBL  = 16,
  parameter int TBL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hit,
  input logic             clr,
  input logic             latched,
  input logic [31:0]      hdr_q,
  input logic [31:0]      cell_hdr,
  input logic [TBL_W-1:0] cell_tbl,
  input logic [TBL_W-1:0] last_tbl,
  input logic [NTBL-1:0]  mon_mask
);
  // R6: first misroute captures header and sets latched bit
  p_capture_first_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && !latched && !clr) |=> (latched && hdr_q == $past(cell_hdr)));

  // R7: stored header holds while latched and not cleared
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (latched && !clr) |=> (latched && $stable(hdr_q)));

  // R9 and R10: clear wins and empties the capture
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!latched && hdr_q == '0));

  // R8: last-table field follows every misroute
  p_last_tbl_r8: assert property (@(posedge clk) disable iff (rst)
    hit |=> (last_tbl == $past(cell_tbl)));

  // R8: last-table field is otherwise stable
  p_last_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(last_tbl));

  // R2: no misroute event for a table outside the monitor mask
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> mon_mask[cell_tbl]);
endmodule

bind misroute_mon misroute_mon_sva #(.NTBL(NTBL), .TBL_W(TBL_W)) u_sva (
  .clk     (clk),
  .rst     (rst),
  .hit     (hit),
  .clr     (clr),
  .latched (latched),
  .hdr_q   (hdr_q),
  .cell_hdr(cell_hdr),
  .cell_tbl(cell_tbl),
  .last_tbl(last_tbl),
  .mon_mask(mon_mask)
);

// File: tb/test_misroute_mon.sv
`timescale 1ns/1ps
module test_misroute_mon;
  localparam int NTBL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cell_vld = 1'b0;
  logic [31:0] cell_hdr = '0;
  logic [3:0]  cell_tbl = '0;
  logic [NTBL*16-1:0] cfg_vci_min, cfg_vci_max;
  logic [NTBL-1:0]    cfg_vpi_chk;
  logic [NTBL*12-1:0] cfg_vpi_unused;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  misroute_mon i_misroute_mon (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_hdr(cell_hdr),
    .cell_tbl(cell_tbl), .cfg_vci_min(cfg_vci_min), .cfg_vci_max(cfg_vci_max),
    .cfg_vpi_chk(cfg_vpi_chk), .cfg_vpi_unused(cfg_vpi_unused),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] mk(input logic [11:0] vpi, input logic [15:0] vci,
                                     input logic [1:0] cls);
    return {vpi, vci, cls, 2'b00};
  endfunction

  // monitor: compare each expected item against read data after the edge
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        #2;
        n_chk++;
        if (reg_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{e, tag});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] h, input logic [3:0] t);
    @(negedge clk);
    cell_vld = 1'b1; cell_hdr = h; cell_tbl = t;
    @(negedge clk);
    cell_vld = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NTBL; t++) begin
      cfg_vci_min[t*16 +: 16]    = 16'd32;
      cfg_vci_max[t*16 +: 16]    = 16'd1000;
      cfg_vpi_unused[t*12 +: 12] = 12'hF00;
      cfg_vpi_chk[t]             = (t == 3);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    rd(16'h0142, 16'hFFFF, "R1 mask reset");
    rd(16'h0144, 16'h0000, "R1 ctrl reset");
    rd(16'h0146, 16'h0000, "R1 hdr high reset");
    rd(16'h0148, 16'h0000, "R1 hdr low reset");
    rd(16'h0150, 16'h0000, "R11 unmapped reads 0");

    send(mk(12'h005, 16'd100, 2'b01), 4'd1);
    rd(16'h0144, 16'h0000, "R3 good cell not flagged");

    wr(16'h0142, 16'hFFFB);
    rd(16'h0142, 16'hFFFB, "R2 mask write");
    send(mk(12'h005, 16'd100, 2'b00), 4'd2);
    rd(16'h0144, 16'h0000, "R2 masked table ignored");

    send(mk(12'h005, 16'd100, 2'b00), 4'd7);
    rd(16'h0144, 16'h0072, "R3 R8 class bits zero flagged");
    rd(16'h0146, 16'h0050, "R6 hdr high");
    rd(16'h0148, 16'h0640, "R6 hdr low");

    send(mk(12'h00A, 16'd2000, 2'b01), 4'd9);
    rd(16'h0144, 16'h0092, "R8 last table follows second cell");
    rd(16'h0146, 16'h0050, "R7 hdr high kept");
    rd(16'h0148, 16'h0640, "R7 hdr low kept");

    wr(16'h0144, 16'h0001);
    rd(16'h0144, 16'h0090, "R9 clear drops latched");
    rd(16'h0146, 16'h0000, "R9 hdr high cleared");
    rd(16'h0148, 16'h0000, "R9 hdr low cleared");

    send(mk(12'h005, 16'd10, 2'b01), 4'd4);
    rd(16'h0144, 16'h0042, "R4 vci below min");
    rd(16'h0148, 16'h00A4, "R4 R6 hdr low of low-vci cell");

    wr(16'h0144, 16'h0001);
    send(mk(12'h100, 16'd100, 2'b01), 4'd3);
    rd(16'h0144, 16'h0032, "R5 unused vpi bit flagged");
    rd(16'h0146, 16'h1000, "R5 hdr high");
    wr(16'h0144, 16'h0001);
    send(mk(12'h100, 16'd100, 2'b01), 4'd5);
    rd(16'h0144, 16'h0030, "R5 vpi check disabled ignores bits");

    // R10: clear and misroute in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 16'h0144; reg_wdata = 16'h0001;
    cell_vld = 1'b1; cell_hdr = mk(12'h005, 16'd100, 2'b00); cell_tbl = 4'd6;
    @(negedge clk);
    reg_wr = 1'b0; cell_vld = 1'b0;
    rd(16'h0144, 16'h0060, "R10 clear wins, last table updates");
    rd(16'h0148, 16'h0000, "R10 header not captured");

    send(mk(12'h005, 16'd32, 2'b10), 4'd1);
    send(mk(12'h005, 16'd1000, 2'b11), 4'd1);
    rd(16'h0144, 16'h0060, "R4 vci on bounds accepted");

    send(mk(12'h005, 16'd1001, 2'b10), 4'd0);
    rd(16'h0144, 16'h0002, "R4 vci just above max");

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule